// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, A and B. Each side has separate input, output and output-enable ports, which a pad ring or an on-chip bus fabric turns into a shared wire. Two storage registers sit between the buses, one per direction, and each has its own clock. The forward register is loaded from the A input, and the reverse register is loaded from the B input. A register is loaded on every rising edge of its clock, whatever the control inputs are doing, so data can be captured while both outputs are switched off.

A decoder turns the active-low output enable and the direction bit into one of three named modes. In `MODE_ISOLATE` (output enable high) neither bus is driven. In `MODE_DRIVE_A` (enable low, direction low) only A is driven. In `MODE_DRIVE_B` (enable low, direction high) only B is driven. The decoder moves from one mode to another combinationally, in the same cycle as a change on the two control inputs. For the bus being driven, a per-direction select chooses between the live input of the opposite bus and the value held in that direction's register. The parameter `INVERT` chooses a data path that passes the value unchanged or one that complements it.

Top module: `regbus_xcvr`

## Requirements
- R1: On every rising edge of `clk_ab` with `rst` low, the forward register loads `a_in`, for any values of `oe_n`, `dir` and the selects.
- R2: On every rising edge of `clk_ba` with `rst` low, the reverse register loads `b_in`, for any values of `oe_n`, `dir` and the selects. A `clk_ab` edge leaves it unchanged.
- R3: A rising edge of a register's own clock with `rst` high clears that register to zero. The other register keeps its value until its own clock has an edge.
- R4: With `oe_n` = 1 (`MODE_ISOLATE`), `a_oe` = 0, `b_oe` = 0, `a_out` = 0 and `b_out` = 0.
- R5: With `oe_n` = 0, `dir` = 0 gives `MODE_DRIVE_A` (`a_oe` = 1, `b_oe` = 0, `b_out` = 0), and `dir` = 1 gives `MODE_DRIVE_B` (`b_oe` = 1, `a_oe` = 0, `a_out` = 0).
- R6: In `MODE_DRIVE_A`, `sel_ba` = 0 puts live `b_in` on `a_out`, `sel_ba` = 1 puts the reverse register on `a_out`, and `sel_ab` has no effect.
- R7: In `MODE_DRIVE_B`, `sel_ab` = 0 puts live `a_in` on `b_out`, `sel_ab` = 1 puts the forward register on `b_out`, and `sel_ba` has no effect.
- R8: `a_oe` and `b_oe` are never 1 at the same time.
- R9: With `INVERT` = 1, the driven output is the bitwise complement of the selected live or stored value. The registers hold the uncomplemented input, so a register cleared by reset is seen as all ones.
- R10: The outputs follow the controls, the bus inputs and the register contents in the same cycle, with no clock edge in between.
- R11: A value captured during `MODE_ISOLATE` appears on the driven bus when stored data is selected later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Forward register clock, A to B |
| clk_ba | input | 1 | Reverse register clock, B to A |
| rst | input | 1 | Synchronous active-high reset, applied in each clock domain |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | Direction: 0 drives A, 1 drives B |
| sel_ab | input | 1 | Source for the B output: 0 live A, 1 forward register |
| sel_ba | input | 1 | Source for the A output: 0 live B, 1 reverse register |
| a_in | input | WIDTH | A bus input value |
| a_out | output | WIDTH | A bus output value |
| a_oe | output | 1 | A bus drive enable |
| b_in | input | WIDTH | B bus input value |
| b_out | output | WIDTH | B bus output value |
| b_oe | output | 1 | B bus drive enable |

## Verification
Two functions can fall in the same cycle: a register capture and the forwarding of that same register onto the driven bus. The bench provokes this by holding `MODE_DRIVE_B` with stored data selected and pulsing `clk_ab` with a new value on `a_in`. It then expects `b_out` to show the new value right after the edge, with no extra cycle of delay. A second case captures during `MODE_ISOLATE`, checks that the outputs stay at zero, and then enables the bus to confirm that the stored value appears.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'd0,
        MODE_DRIVE_A = 2'd1,
        MODE_DRIVE_B = 2'd2
    } xfer_mode_e;

endpackage

// File: rtl/regbus_xcvr_mode_dec.sv
module regbus_xcvr_mode_dec
    import regbus_xcvr_pkg::*;
(
    input  logic       oe_n,
    input  logic       dir,
    output xfer_mode_e mode,
    output logic       drive_a,
    output logic       drive_b
);

    // Mode selection from the control pins
    always_comb begin
        if (oe_n) begin
            mode = MODE_ISOLATE;
        end else if (dir) begin
            mode = MODE_DRIVE_B;
        end else begin
            mode = MODE_DRIVE_A;
        end
    end

    // Enables per mode
    always_comb begin
        drive_a = 1'b0;
        drive_b = 1'b0;
        unique case (mode)
            MODE_ISOLATE: begin
                drive_a = 1'b0;
                drive_b = 1'b0;
            end
            MODE_DRIVE_A: drive_a = 1'b1;
            MODE_DRIVE_B: drive_b = 1'b1;
            default: begin
                drive_a = 1'b0;
                drive_b = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/regbus_xcvr_store.sv
module regbus_xcvr_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/regbus_xcvr_path.sv
module regbus_xcvr_path #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             enable,
    input  logic             use_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] picked;
    logic [WIDTH-1:0] shaped;

    assign picked = use_stored ? stored : live;

    generate
        if (INVERT) begin : g_invert
            assign shaped = ~picked;
        end else begin : g_pass
            assign shaped = picked;
        end
    endgenerate

    assign dout = enable ? shaped : '0;

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import regbus_xcvr_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    xfer_mode_e       mode;
    logic             drive_a;
    logic             drive_b;
    logic [WIDTH-1:0] ab_store_q;
    logic [WIDTH-1:0] ba_store_q;

    regbus_xcvr_mode_dec u_dec (
        .oe_n    (oe_n),
        .dir     (dir),
        .mode    (mode),
        .drive_a (drive_a),
        .drive_b (drive_b)
    );

    // Forward register, clk_ab domain (R1, R3)
    regbus_xcvr_store #(.WIDTH(WIDTH)) u_store_ab (
        .clk (clk_ab),
        .rst (rst),
        .d   (a_in),
        .q   (ab_store_q)
    );

    // Reverse register, clk_ba domain (R2, R3)
    regbus_xcvr_store #(.WIDTH(WIDTH)) u_store_ba (
        .clk (clk_ba),
        .rst (rst),
        .d   (b_in),
        .q   (ba_store_q)
    );

    // Path onto A: live B or reverse register (R6)
    regbus_xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_a (
        .enable     (drive_a),
        .use_stored (sel_ba),
        .live       (b_in),
        .stored     (ba_store_q),
        .dout       (a_out)
    );

    // Path onto B: live A or forward register (R7)
    regbus_xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_b (
        .enable     (drive_b),
        .use_stored (sel_ab),
        .live       (a_in),
        .stored     (ab_store_q),
        .dout       (b_out)
    );

    assign a_oe = drive_a;
    assign b_oe = drive_b;

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk_ab,
    input logic             clk_ba,
    input logic             rst,
    input logic             oe_n,
    input logic             dir,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             a_oe,
    input logic             b_oe,
    input logic [WIDTH-1:0] ab_store_q,
    input logic [WIDTH-1:0] ba_store_q
);

    assert_capture_ab_R1: assert property (@(posedge clk_ab) disable iff (rst)
        1'b1 |=> ab_store_q == $past(a_in));

    assert_capture_ba_R2: assert property (@(posedge clk_ba) disable iff (rst)
        1'b1 |=> ba_store_q == $past(b_in));

    assert_isolate_R4: assert property (@(posedge clk_ab) disable iff (rst)
        oe_n |-> (!a_oe && !b_oe));

    assert_drive_side_R5: assert property (@(posedge clk_ab) disable iff (rst)
        !oe_n |-> ((a_oe == !dir) && (b_oe == dir)));

    assert_one_side_R8: assert property (@(posedge clk_ba) disable iff (rst)
        !(a_oe && b_oe));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) chk_i (
    .clk_ab     (clk_ab),
    .clk_ba     (clk_ba),
    .rst        (rst),
    .oe_n       (oe_n),
    .dir        (dir),
    .a_in       (a_in),
    .b_in       (b_in),
    .a_oe       (a_oe),
    .b_oe       (b_oe),
    .ab_store_q (ab_store_q),
    .ba_store_q (ba_store_q)
);

// File: tb/regbus_xcvr_tb_top.sv
`timescale 1ns/1ps
module regbus_xcvr_tb_top;

    typedef struct packed {
        logic       oe_n;
        logic       dir;
        logic       sel_ab;
        logic       sel_ba;
        logic [7:0] a;
        logic [7:0] b;
        logic       exp_aoe;
        logic       exp_boe;
        logic [7:0] exp_a;
        logic [7:0] exp_b;
    } vec_t;

    // Registers preloaded: forward = 3C, reverse = A5
    localparam vec_t VECS [0:7] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b0, 8'h00, 8'h00}, // R4
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h11, 8'h22, 1'b0, 1'b0, 8'h00, 8'h00}, // R4
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 1'b1, 1'b0, 8'h22, 8'h00}, // R5 R6 live
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'h11, 8'h22, 1'b1, 1'b0, 8'hA5, 8'h00}, // R6 stored
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h77, 8'h5A, 1'b1, 1'b0, 8'h5A, 8'h00}, // R6 sel_ab ignored
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b1, 8'h00, 8'h11}, // R5 R7 live
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'h11, 8'h22, 1'b0, 1'b1, 8'h00, 8'h3C}, // R7 stored
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'hF0, 8'h0F, 1'b0, 1'b1, 8'h00, 8'hF0}  // R7 sel_ba ignored
    };

    logic       clk = 1'b0;
    logic       clk_ab = 1'b0;
    logic       clk_ba = 1'b0;
    logic       rst = 1'b1;
    logic       oe_n = 1'b1;
    logic       dir = 1'b0;
    logic       sel_ab = 1'b0;
    logic       sel_ba = 1'b0;
    logic [7:0] a_in = 8'h00;
    logic [7:0] b_in = 8'h00;
    logic [7:0] a_out, b_out, a_out_v, b_out_v;
    logic       a_oe, b_oe, a_oe_v, b_oe_v;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    regbus_xcvr #(.WIDTH(8), .INVERT(1'b0)) dut_i (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out),
        .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    regbus_xcvr #(.WIDTH(8), .INVERT(1'b1)) dut_inv_i (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out_v),
        .a_oe(a_oe_v), .b_in(b_in), .b_out(b_out_v), .b_oe(b_oe_v)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(input logic o, input logic d, input logic sab, input logic sba);
        @(negedge clk);
        oe_n = o; dir = d; sel_ab = sab; sel_ba = sba;
        #2;
    endtask

    task automatic pulse_ab();
        @(negedge clk); clk_ab = 1'b1;
        @(negedge clk); clk_ab = 1'b0;
        #2;
    endtask

    task automatic pulse_ba();
        @(negedge clk); clk_ba = 1'b1;
        @(negedge clk); clk_ba = 1'b0;
        #2;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            finish_run();
        end
    end

    initial begin
        // Reset both domains (R3)
        rst = 1'b1;
        a_in = 8'h5F; b_in = 8'hE1;
        pulse_ab();
        pulse_ba();
        rst = 1'b0;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R3 forward reg zero after reset", b_out, 8'h00);
        check("R9 inverted reset value", b_out_v, 8'hFF);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R3 reverse reg zero after reset", a_out, 8'h00);

        // Capture in isolation, seen later (R11, R1, R2)
        set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
        a_in = 8'h3C; b_in = 8'hA5;
        pulse_ab();
        pulse_ba();
        check("R4 outputs idle during capture", a_out | b_out, 8'h00);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R11 isolated capture forward", b_out, 8'h3C);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R11 isolated capture reverse", a_out, 8'hA5);

        // Clock independence: clk_ab edge leaves reverse reg (R2)
        b_in = 8'h66;
        a_in = 8'h3C;
        pulse_ab();
        check("R2 reverse reg untouched by clk_ab", a_out, 8'hA5);
        b_in = 8'h22;

        // Vector table
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            oe_n = VECS[i].oe_n; dir = VECS[i].dir;
            sel_ab = VECS[i].sel_ab; sel_ba = VECS[i].sel_ba;
            a_in = VECS[i].a; b_in = VECS[i].b;
            #2;
            check($sformatf("R5 vec%0d a_oe", i), {7'd0, a_oe}, {7'd0, VECS[i].exp_aoe});
            check($sformatf("R8 vec%0d b_oe", i), {7'd0, b_oe}, {7'd0, VECS[i].exp_boe});
            check($sformatf("R6 vec%0d a_out", i), a_out, VECS[i].exp_a);
            check($sformatf("R7 vec%0d b_out", i), b_out, VECS[i].exp_b);
            check($sformatf("R9 vec%0d a_out inv", i), a_out_v,
                  VECS[i].exp_aoe ? ~VECS[i].exp_a : 8'h00);
            check($sformatf("R9 vec%0d b_out inv", i), b_out_v,
                  VECS[i].exp_boe ? ~VECS[i].exp_b : 8'h00);
        end

        // Combinational follow with no clock (R10)
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        b_in = 8'hC3;
        #1;
        check("R10 live B follows immediately", a_out, 8'hC3);

        // Capture while driving, same register forwarded (R1, R10)
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        a_in = 8'h99;
        check("R1 before edge stored kept", b_out, 8'h3C);
        pulse_ab();
        check("R1 capture while driving B", b_out, 8'h99);
        check("R9 inverted stored path", b_out_v, 8'h66);

        // Capture regardless of direction: clk_ba while driving B (R2)
        b_in = 8'h4B;
        pulse_ba();
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R2 capture while B was driven", a_out, 8'h4B);

        // Reset on one domain only (R3)
        rst = 1'b1;
        pulse_ab();
        rst = 1'b0;
        check("R3 reverse keeps value after clk_ab reset", a_out, 8'h4B);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R3 forward cleared by its reset", b_out, 8'h00);

        finish_run();
    end

endmodule